// File: doc/BRIEF.md
# Dual-Mode Binary / Galois-Field Multiply-Accumulate Unit

This datapath unit serves a signal processor that must handle both ordinary fixed-point arithmetic and the finite-field arithmetic of block-code decoding. In binary mode it is a signed 16x16 multiply-accumulate with a 40-bit accumulator. In Galois mode it works in GF(2^8) and offers four operations. The first is a multiply-accumulate, used for the discrepancy sum of the key equation. The second is an accumulate-multiply, where the accumulator feeds the multiplier and which performs one Horner step of polynomial evaluation. The third is a non-accumulating multiply-add that uses a held scaling constant, used for locator polynomial updates. The fourth is a division, built from a constant inversion table and the multiplier.

All four Galois dataflows share one combinational GF(2^8) multiplier, and its operands are chosen per opcode. A separate constant register holds the scaling factor, so a polynomial update needs only two operand buses per cycle. Sequencing of the decoding algorithm is left to the controller that drives the opcode.

Top module: `gf_bin_mac`

Opcode encoding on `opcode_i`: 0 = HOLD, 1 = BMAC (binary), 2 = GMAC, 3 = GACM, 4 = GMAD, 5 = GDIV, 6 and 7 = undefined (treated as HOLD). In GF(2^8), addition is bitwise XOR and multiplication is reduced by x^8+x^4+x^3+x^2+1 (0x11D). Each operation below describes the accumulator value after the rising clock edge.

## Requirements
- R1: After reset, or one cycle after `clr_i` is high, the accumulator is 0 and `div_err_o` is 0. `clr_i` takes priority over every opcode, but it does not block a constant load.
- R2: BMAC (1) adds the signed product of `op_a_i` and `op_b_i`, sign-extended to 40 bits, to the accumulator. The sum wraps modulo 2^40.
- R3: GMAC (2) produces acc[7:0] XOR (a[7:0] * b[7:0]) in GF(2^8).
- R4: GACM (3) produces (acc[7:0] * a[7:0]) XOR b[7:0] in GF(2^8).
- R5: When `ld_const_i` is high, the constant register takes `op_b_i[7:0]` at the clock edge. A GMAD in the same cycle still uses the previous constant. A load alone leaves the accumulator unchanged.
- R6: GMAD (4) produces a[7:0] XOR (const * b[7:0]) in GF(2^8). The old accumulator value has no effect on the result.
- R7: GDIV (5) produces a[7:0] * inverse(b[7:0]) and clears `div_err_o`. When b[7:0] is 0, the result is 0 and `div_err_o` is set. Outside GDIV and clear, `div_err_o` holds its value.
- R8: Every Galois result uses only bits [7:0] of each operand and leaves acc[39:8] at 0. For example, 0x02 * 0x80 gives 0x1D.
- R9: `zero_o` is 1 exactly when the accumulator output is 0.
- R10: Opcodes 0, 6 and 7 leave the accumulator and `div_err_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a_i | input | 16 | Operand A (Galois modes use bits [7:0]) |
| op_b_i | input | 16 | Operand B (Galois modes use bits [7:0]) |
| opcode_i | input | 3 | Operation select |
| ld_const_i | input | 1 | Load `op_b_i[7:0]` into the constant register |
| clr_i | input | 1 | Clear accumulator and error flag |
| acc_o | output | 40 | Accumulator value |
| zero_o | output | 1 | Accumulator equals zero |
| div_err_o | output | 1 | Last division had a zero divisor |

## Verification
Two situations are hardest to reach. The first is the 40-bit wrap in binary mode: it takes more than a thousand maximal products of the same sign. The bench feeds a long run of (-32768) x (-32768) products and lets a behavioural model follow the carry out of bit 39. The second is the same-cycle overlap of a constant load with GMAD, together with a divide-by-zero followed by a hold. Directed steps place a load and a GMAD on the same edge, then a zero divisor followed by HOLD. Many random cycles then mix every opcode with noisy high operand bits. Throughout, a log/antilog model of the field checks every output on every cycle.

// File: rtl/gfmac_pkg.sv
package gfmac_pkg;

    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_BMAC = 3'd1,
        OP_GMAC = 3'd2,
        OP_GACM = 3'd3,
        OP_GMAD = 3'd4,
        OP_GDIV = 3'd5
    } op_e;

    localparam int GW = 8;
    localparam logic [GW-1:0] GF_POLY = 8'h1D;

    function automatic logic [GW-1:0] gf_xtime(input logic [GW-1:0] v);
        return v[GW-1] ? ((v << 1) ^ GF_POLY) : (v << 1);
    endfunction

    function automatic logic [GW-1:0] gf_mul_f(input logic [GW-1:0] x,
                                               input logic [GW-1:0] y);
        logic [GW-1:0] acc;
        logic [GW-1:0] sh;
        acc = '0;
        sh  = x;
        for (int i = 0; i < GW; i++) begin
            if (y[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

endpackage

// File: rtl/gf_mul.sv
module gf_mul
    import gfmac_pkg::*;
(
    input  logic [GW-1:0] x_i,
    input  logic [GW-1:0] y_i,
    output logic [GW-1:0] p_o
);
    always_comb begin
        p_o = gf_mul_f(x_i, y_i);
    end
endmodule

// File: rtl/gf_inv_rom.sv
module gf_inv_rom
    import gfmac_pkg::*;
(
    input  logic [GW-1:0] x_i,
    output logic [GW-1:0] y_o
);
    localparam int ENTRIES = 1 << GW;

    function automatic logic [ENTRIES*GW-1:0] build_tab();
        logic [ENTRIES*GW-1:0] t;
        logic [GW-1:0] r;
        logic [GW-1:0] s;
        t = '0;
        for (int v = 1; v < ENTRIES; v++) begin
            r = 8'h01;
            s = GW'(v);
            for (int k = 1; k < GW; k++) begin
                s = gf_mul_f(s, s);
                r = gf_mul_f(r, s);
            end
            t[v*GW +: GW] = r;
        end
        return t;
    endfunction

    localparam logic [ENTRIES*GW-1:0] INV_TAB = build_tab();

    always_comb begin
        y_o = INV_TAB[x_i*GW +: GW];
    end
endmodule

// File: rtl/bin_mul.sv
module bin_mul #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    output logic [2*DW-1:0] p_o
);
    always_comb begin
        p_o = $signed(a_i) * $signed(b_i);
    end
endmodule

// File: rtl/gf_bin_mac.sv
module gf_bin_mac
    import gfmac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] op_a_i,
    input  logic [DW-1:0] op_b_i,
    input  logic [2:0]    opcode_i,
    input  logic          ld_const_i,
    input  logic          clr_i,
    output logic [AW-1:0] acc_o,
    output logic          zero_o,
    output logic          div_err_o
);
    localparam int PW  = 2 * DW;
    localparam int EXT = AW - PW;

    op_e           op;
    logic [AW-1:0] acc_q, acc_d;
    logic          err_q, err_d;
    logic [GW-1:0] k_q;
    logic [GW-1:0] a8, b8, acc8, inv_b;
    logic [GW-1:0] mx, my, gp;
    logic [PW-1:0] bprod;

    assign op   = op_e'(opcode_i);
    assign a8   = op_a_i[GW-1:0];
    assign b8   = op_b_i[GW-1:0];
    assign acc8 = acc_q[GW-1:0];

    gf_inv_rom u_inv  (.x_i(b8), .y_o(inv_b));
    gf_mul     u_gmul (.x_i(mx), .y_i(my), .p_o(gp));
    bin_mul #(.DW(DW)) u_bmul (.a_i(op_a_i), .b_i(op_b_i), .p_o(bprod));

    // Operand steering into the single shared field multiplier
    always_comb begin
        mx = a8;
        my = b8;
        unique case (op)
            OP_GACM: begin mx = acc8; my = a8;    end
            OP_GMAD: begin mx = k_q;  my = b8;    end
            OP_GDIV: begin mx = a8;   my = inv_b; end
            default: begin mx = a8;   my = b8;    end
        endcase
    end

    always_comb begin
        acc_d = acc_q;
        err_d = err_q;
        if (clr_i) begin
            acc_d = '0;
            err_d = 1'b0;
        end else begin
            unique case (op)
                OP_BMAC: acc_d = acc_q + {{EXT{bprod[PW-1]}}, bprod};
                OP_GMAC: acc_d = {{(AW-GW){1'b0}}, acc8 ^ gp};
                OP_GACM: acc_d = {{(AW-GW){1'b0}}, gp ^ b8};
                OP_GMAD: acc_d = {{(AW-GW){1'b0}}, a8 ^ gp};
                OP_GDIV: begin
                    acc_d = {{(AW-GW){1'b0}}, gp};
                    err_d = (b8 == '0);
                end
                default: acc_d = acc_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            err_q <= 1'b0;
            k_q   <= '0;
        end else begin
            acc_q <= acc_d;
            err_q <= err_d;
            if (ld_const_i) k_q <= b8;
        end
    end

    assign acc_o     = acc_q;
    assign zero_o    = (acc_q == '0);
    assign div_err_o = err_q;

    // R1: clear wins over any opcode
    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (acc_o == '0 && !div_err_o));

    // R8: Galois results never reach the upper accumulator bits
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!clr_i) && ($past(opcode_i) inside {3'd2, 3'd3, 3'd4, 3'd5}))
        |-> (acc_o[AW-1:GW] == '0));

    // R7: zero divisor gives zero and raises the error flag
    a_r7_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!clr_i) && $past(opcode_i) == 3'd5 && $past(op_b_i[GW-1:0]) == '0)
        |-> (acc_o == '0 && div_err_o));

    // R10: holding opcodes change nothing
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!clr_i) && ($past(opcode_i) inside {3'd0, 3'd6, 3'd7}))
        |-> ($stable(acc_o) && $stable(div_err_o)));

    // R9: zero flag agrees with accumulator
    a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o == (acc_o == '0));
endmodule

// File: tb/gf_bin_mac_tb.sv
module gf_bin_mac_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic [2:0]  opcode = '0;
    logic        ld_const = 1'b0, clr = 1'b0;
    logic [39:0] acc;
    logic        zero, div_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int exp_t[0:255];
    int log_t[0:255];

    logic [39:0] m_acc = '0;
    logic        m_err = 1'b0;
    int          m_k = 0;

    always #5 clk = ~clk;

    gf_bin_mac u_dut (
        .clk(clk), .rst_n(rst_n), .op_a_i(op_a), .op_b_i(op_b),
        .opcode_i(opcode), .ld_const_i(ld_const), .clr_i(clr),
        .acc_o(acc), .zero_o(zero), .div_err_o(div_err)
    );

    function automatic int gm(int x, int y);
        if (x == 0 || y == 0) return 0;
        return exp_t[(log_t[x] + log_t[y]) % 255];
    endfunction

    function automatic int ginv(int x);
        return exp_t[(255 - log_t[x]) % 255];
    endfunction

    task automatic chk(string tag, logic [39:0] got, logic [39:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, want);
        end
    endtask

    function automatic string tag_of(logic [2:0] o, logic c);
        if (c) return "R1";
        case (o)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic model_update();
        int a, b;
        longint p;
        a = int'(op_a[7:0]);
        b = int'(op_b[7:0]);
        if (clr) begin
            m_acc = '0;
            m_err = 1'b0;
        end else begin
            case (opcode)
                3'd1: begin
                    p = longint'($signed(op_a)) * longint'($signed(op_b));
                    m_acc = m_acc + p[39:0];
                end
                3'd2: m_acc = 40'(int'(m_acc[7:0]) ^ gm(a, b));
                3'd3: m_acc = 40'(gm(int'(m_acc[7:0]), a) ^ b);
                3'd4: m_acc = 40'(a ^ gm(m_k, b));
                3'd5: begin
                    m_acc = (b == 0) ? 40'd0 : 40'(gm(a, ginv(b)));
                    m_err = (b == 0);
                end
                default: ;
            endcase
        end
        if (ld_const) m_k = b;
    endtask

    // Called just after a falling edge: drive, clock, compare.
    task automatic step(logic [2:0] o, logic [15:0] a, logic [15:0] b,
                        logic ldk, logic c);
        string t;
        opcode = o; op_a = a; op_b = b; ld_const = ldk; clr = c;
        t = tag_of(o, c);
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk(t, acc, m_acc);
        chk({t, "/R9 zero"}, {39'd0, zero}, {39'd0, m_acc == 40'd0});
        chk({t, " err"}, {39'd0, div_err}, {39'd0, m_err});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int v;
        v = 1;
        for (int i = 0; i < 255; i++) begin
            exp_t[i] = v;
            log_t[v] = i;
            v = v << 1;
            if (v & 256) v = v ^ 'h11D;
        end
        log_t[0] = 0;

        repeat (3) @(negedge clk);
        chk("R1 reset acc", acc, 40'd0);
        chk("R1 reset err", {39'd0, div_err}, 40'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: field polynomial and ignored high bits
        step(3'd2, 16'hAB02, 16'hCD80, 1'b0, 1'b0);
        chk("R8 poly", acc, 40'h1D);
        // R3 accumulates by XOR
        step(3'd2, 16'h0003, 16'h0007, 1'b0, 1'b0);
        // R1: clear overrides GMAC
        step(3'd2, 16'h0055, 16'h0066, 1'b0, 1'b1);
        chk("R1 clr priority", acc, 40'd0);
        // R4: Horner steps
        step(3'd3, 16'h0002, 16'h0011, 1'b0, 1'b0);
        step(3'd3, 16'h0002, 16'h0022, 1'b0, 1'b0);
        step(3'd3, 16'hFF8E, 16'h0033, 1'b0, 1'b0);
        // R5: load alone holds acc
        step(3'd0, 16'h0000, 16'h0045, 1'b1, 1'b0);
        // R5: load with GMAD uses old constant 0x45
        step(3'd4, 16'h0010, 16'h0003, 1'b1, 1'b0);
        chk("R5 old const", acc, 40'(16 ^ gm('h45, 3)));
        step(3'd4, 16'h0010, 16'h0003, 1'b0, 1'b0);
        chk("R6 new const", acc, 40'(16 ^ gm(3, 3)));
        // R7: divide, zero divisor, hold, recovery
        step(3'd5, 16'h0037, 16'h0009, 1'b0, 1'b0);
        chk("R7 divide", acc, 40'(gm('h37, ginv(9))));
        step(3'd5, 16'h0037, 16'hFF00, 1'b0, 1'b0);
        chk("R7 div by zero err", {39'd0, div_err}, 40'd1);
        step(3'd6, 16'h1234, 16'h5678, 1'b0, 1'b0);
        chk("R10 err held", {39'd0, div_err}, 40'd1);
        step(3'd5, 16'h0001, 16'h0001, 1'b0, 1'b0);
        chk("R7 err cleared", {39'd0, div_err}, 40'd0);
        step(3'd1, 16'h0000, 16'h0000, 1'b0, 1'b1);

        // R2: signed binary, then wrap modulo 2^40
        step(3'd1, 16'hFFFD, 16'h0007, 1'b0, 1'b0);
        chk("R2 signed", acc, 40'hFF_FFFF_FFEB);
        step(3'd1, 16'h0000, 16'h0000, 1'b0, 1'b1);
        for (int i = 0; i < 1100; i++)
            step(3'd1, 16'h8000, 16'h8000, 1'b0, 1'b0);
        chk("R2 wrap", acc, 40'(64'd1100 << 30));
        step(3'd7, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);

        // Random mix of all opcodes
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] o;
            logic [15:0] a, b;
            o = 3'($urandom_range(0, 7));
            a = 16'($urandom);
            b = 16'($urandom);
            if ($urandom_range(0, 9) == 0) b[7:0] = 8'h00;
            step(o, a, b, ($urandom_range(0, 5) == 0),
                 ($urandom_range(0, 30) == 0));
        end

        finish_run();
    end
endmodule